// File: doc/BRIEF.md
# Serial Fault Register with Daisy-Chain Read

This block holds a two-bit fault code for each of four load channels and makes those codes readable over a four-wire serial port: an active-low select, a serial clock, a data input and a data output. Channel fault logic writes a new code for a channel by raising that channel's write strobe for one clock. While the port is not selected, the data output acts as an attention line. It goes low as soon as any channel holds a code other than "normal", so a host can poll one pin and read only when something has happened.

When the host pulls select low, the four codes are captured in parallel into an eight-bit frame. The frame is then shifted out one bit per serial clock. Bits arriving on the data input are shifted in behind the local frame, so several devices can share one read with each device's output feeding the next device's input. Releasing select clears every code back to normal. A code written while a read is in progress is held in a pending slot and becomes the channel's code after that clear. The synchronous reset also clears all codes, as does the low-supply condition that drives it.

The serial clock and the select line are asynchronous to the system clock. Each passes through a two-flop synchronizer and an edge detector before any state acts on it.

Top module: `fault_chain_reg`

## Requirements
- R1: Channel codes use 2'b11 = normal, 2'b10 = overload or shorted load, 2'b01 = open load and 2'b00 = shorted to ground. A strobe on `flt_we[i]` while deselected replaces channel i's code with `flt_code[2i+1:2i]`, and the latest write wins.
- R2: While `csn_i` is high (deselected), `sdo_o` is 0 if any channel holds a code other than 2'b11, and 1 otherwise.
- R3: When `csn_i` falls, the frame is loaded and its first bit is presented on `sdo_o` before the first serial clock. Frame bit order is channel 0 code bit 1, then channel 0 code bit 0, then channel 1 code bit 1, and so on up to channel 3 code bit 0 (eight bits).
- R4: While selected, `sdo_o` moves to the next bit only after a falling `sclk_i` edge and stays constant across the rising edge, at which a host samples it.
- R5: `sdi_i` is sampled on each rising `sclk_i` edge while selected. After the eight local bits, `sdo_o` presents the upstream bits in the order they arrived.
- R6: A rising edge on `csn_i` returns every channel code to 2'b11, unless a code is pending for that channel (R7).
- R7: A strobe that arrives while selected leaves the stored codes and the frame being shifted unchanged. After the next rising edge of `csn_i`, the strobed code becomes that channel's code.
- R8: `rst` (active high, synchronous) sets all codes to 2'b11 and discards any pending code, so `sdo_o` reads 1 once the port is deselected.
- R9: `sclk_i` and `sdi_i` activity while deselected changes neither the codes nor `sdo_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, also used for low supply |
| flt_we | input | NCH | Per-channel fault code write strobe |
| flt_code | input | NCH*2 | Per-channel fault code, channel i in bits [2i+1:2i] |
| sclk_i | input | 1 | Serial clock, asynchronous |
| csn_i | input | 1 | Serial select, active low, asynchronous |
| sdi_i | input | 1 | Serial data in from upstream device |
| sdo_o | output | 1 | Attention flag when deselected, frame data when selected |

## Verification
The bench builds the block with its defaults: four channels and a two-stage synchronizer. Four channels give an eight-bit local frame, short enough to read it together with an eight-bit upstream tail in one 16-clock transfer. That makes the ordering of local bits ahead of cascaded bits directly observable. A two-stage synchronizer keeps the edge latency at three system clocks, well inside the six-clock serial half periods the bench drives. This leaves room to check that the output holds steady across each rising serial edge, and to place a channel strobe in the middle of a read.

// File: rtl/fcr_pkg.sv
package fcr_pkg;

    localparam int CODE_W = 2;

    typedef enum logic [CODE_W-1:0] {
        FLT_GND  = 2'b00,
        FLT_OPEN = 2'b01,
        FLT_OVLD = 2'b10,
        FLT_NONE = 2'b11
    } flt_code_e;

    // pending code captured while a read is in progress
    typedef struct packed {
        logic                  valid;
        logic [CODE_W-1:0]     code;
    } pend_t;

    // synchronized level plus its one-cycle-old copy
    typedef struct packed {
        logic level;
        logic prev;
    } sync_pair_t;

    function automatic logic is_fault(input logic [CODE_W-1:0] c);
        return c != FLT_NONE;
    endfunction

    function automatic logic rose(input sync_pair_t p);
        return p.level & ~p.prev;
    endfunction

    function automatic logic fell(input sync_pair_t p);
        return ~p.level & p.prev;
    endfunction

endpackage

// File: rtl/fcr_sync.sv
module fcr_sync
    import fcr_pkg::*;
#(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       din,
    output sync_pair_t sp
);
    logic [STAGES-1:0] chain;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain  <= {STAGES{RST_VAL}};
            prev_q <= RST_VAL;
        end else begin
            chain  <= {chain[STAGES-2:0], din};
            prev_q <= chain[STAGES-1];
        end
    end

    assign sp.level = chain[STAGES-1];
    assign sp.prev  = prev_q;

endmodule

// File: rtl/fcr_code_bank.sv
module fcr_code_bank
    import fcr_pkg::*;
#(
    parameter int NCH = 4,
    localparam int NB = NCH * CODE_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           sel,
    input  logic           clr,
    input  logic [NCH-1:0] we,
    input  logic [NB-1:0]  wcode,
    output logic [NB-1:0]  codes,
    output logic           any_fault,
    output logic           pend_any
);
    logic [NCH-1:0] flt_vec;
    logic [NCH-1:0] pv_vec;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic [CODE_W-1:0] cur;
        pend_t             pnd;
        logic [CODE_W-1:0] nv;

        assign nv = wcode[i*CODE_W +: CODE_W];

        always_ff @(posedge clk) begin
            if (rst) begin
                cur <= FLT_NONE;
                pnd <= '0;
            end else begin
                if (clr) begin
                    cur <= pnd.valid ? pnd.code : FLT_NONE;
                    pnd <= '0;
                end
                if (we[i]) begin
                    if (sel) begin
                        pnd.valid <= 1'b1;
                        pnd.code  <= nv;
                    end else begin
                        cur <= nv;
                    end
                end
            end
        end

        assign codes[i*CODE_W +: CODE_W] = cur;
        assign flt_vec[i] = is_fault(cur);
        assign pv_vec[i]  = pnd.valid;
    end

    assign any_fault = |flt_vec;
    assign pend_any  = |pv_vec;

endmodule

// File: rtl/fcr_shifter.sv
module fcr_shifter #(
    parameter int NB = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [NB-1:0] frame,
    input  logic          sample,
    input  logic          shift,
    input  logic          sdi,
    output logic [NB-1:0] sr
);
    logic din_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr    <= '1;
            din_q <= 1'b1;
        end else begin
            if (load) begin
                sr <= frame;
            end else if (shift) begin
                sr <= {sr[NB-2:0], din_q};
            end
            if (sample) begin
                din_q <= sdi;
            end
        end
    end

endmodule

// File: rtl/fault_chain_reg.sv
module fault_chain_reg
    import fcr_pkg::*;
#(
    parameter int NCH         = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NCH-1:0]        flt_we,
    input  logic [NCH*CODE_W-1:0] flt_code,
    input  logic                  sclk_i,
    input  logic                  csn_i,
    input  logic                  sdi_i,
    output logic                  sdo_o
);
    localparam int NB = NCH * CODE_W;

    sync_pair_t    cs_sp, sk_sp;
    logic          sel, cs_rise, cs_fall, sclk_rise, sclk_fall;
    logic [NB-1:0] codes, frame, sr;
    logic          any_fault, pend_any;

    fcr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
        .clk(clk), .rst(rst), .din(csn_i), .sp(cs_sp)
    );

    fcr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sk_sync (
        .clk(clk), .rst(rst), .din(sclk_i), .sp(sk_sp)
    );

    assign sel       = ~cs_sp.level;
    assign cs_rise   = rose(cs_sp);
    assign cs_fall   = fell(cs_sp);
    assign sclk_rise = rose(sk_sp);
    assign sclk_fall = fell(sk_sp);

    fcr_code_bank #(.NCH(NCH)) u_bank (
        .clk(clk), .rst(rst), .sel(sel), .clr(cs_rise),
        .we(flt_we), .wcode(flt_code), .codes(codes),
        .any_fault(any_fault), .pend_any(pend_any)
    );

    // channel 0 occupies the two most significant frame bits, sent first
    for (genvar i = 0; i < NCH; i++) begin : g_frame
        assign frame[NB-1-i*CODE_W -: CODE_W] = codes[i*CODE_W +: CODE_W];
    end

    fcr_shifter #(.NB(NB)) u_shift (
        .clk(clk), .rst(rst), .load(cs_fall), .frame(frame),
        .sample(sel & sclk_rise), .shift(sel & sclk_fall),
        .sdi(sdi_i), .sr(sr)
    );

    assign sdo_o = sel ? sr[NB-1] : ~any_fault;

endmodule

// File: rtl/fcr_checker.sv
module fcr_checker
    import fcr_pkg::*;
#(
    parameter int NCH = 4,
    localparam int NB = NCH * CODE_W
) (
    input logic           clk,
    input logic           rst,
    input logic           sel,
    input logic           cs_rise,
    input logic           cs_fall,
    input logic           sclk_fall,
    input logic           pend_any,
    input logic [NCH-1:0] we,
    input logic [NB-1:0]  codes,
    input logic [NB-1:0]  sr
);
    function automatic logic [NB-1:0] to_frame(input logic [NB-1:0] c);
        logic [NB-1:0] f;
        for (int i = 0; i < NCH; i++) begin
            f[NB-1-i*CODE_W -: CODE_W] = c[i*CODE_W +: CODE_W];
        end
        return f;
    endfunction

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (codes == {NB{1'b1}} && !pend_any))
        else $error("reset did not clear codes"); // R8

    AST_RELEASE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (cs_rise && !pend_any && we == '0) |=> codes == {NB{1'b1}})
        else $error("release did not clear codes"); // R6

    AST_SELECT_DEFERS: assert property (@(posedge clk) disable iff (rst)
        sel |=> $stable(codes))
        else $error("codes changed during read"); // R7

    AST_LOAD_ORDER: assert property (@(posedge clk) disable iff (rst)
        cs_fall |=> sr == to_frame($past(codes)))
        else $error("frame load order wrong"); // R3

    AST_SHIFT_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (sel && !sclk_fall && !cs_fall) |=> $stable(sr))
        else $error("frame moved without falling clock"); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !sel |=> $stable(sr))
        else $error("frame moved while deselected"); // R9

endmodule

bind fault_chain_reg fcr_checker #(.NCH(NCH)) chk_i (
    .clk(clk), .rst(rst), .sel(sel), .cs_rise(cs_rise), .cs_fall(cs_fall),
    .sclk_fall(sclk_fall), .pend_any(pend_any), .we(flt_we),
    .codes(codes), .sr(sr)
);

// File: tb/fault_chain_reg_tb_top.sv
module fault_chain_reg_tb_top;
    localparam int NCH = 4;
    localparam int NB  = NCH * 2;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NCH-1:0] we = '0;
    logic [NB-1:0]  wcode = '1;
    logic           sclk = 1'b0, csn = 1'b1, sdi = 1'b1;
    logic           sdo;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    fault_chain_reg #(.NCH(NCH), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst), .flt_we(we), .flt_code(wcode),
        .sclk_i(sclk), .csn_i(csn), .sdi_i(sdi), .sdo_o(sdo)
    );

    // ---------------- behavioural reference model ----------------
    int m_code[NCH];
    int m_pend[NCH];
    bit m_pv[NCH];
    bit m_sr[$];
    bit m_din;
    bit c_in, c_lvl, c_old, k_in, k_lvl, k_old;

    function automatic bit model_sdo();
        bit flag = 1'b1;
        if (!c_lvl) return m_sr[0];
        for (int c = 0; c < NCH; c++) if (m_code[c] != 3) flag = 1'b0;
        return flag;
    endfunction

    always @(posedge clk) begin
        bit sel, crise, cfall, krise, kfall;
        if (rst) begin
            for (int c = 0; c < NCH; c++) begin m_code[c] = 3; m_pv[c] = 0; m_pend[c] = 3; end
            m_sr.delete();
            for (int b = 0; b < NB; b++) m_sr.push_back(1'b1);
            m_din = 1'b1;
            c_in = 1; c_lvl = 1; c_old = 1; k_in = 0; k_lvl = 0; k_old = 0;
        end else begin
            sel   = !c_lvl;
            crise = c_lvl && !c_old;
            cfall = !c_lvl && c_old;
            krise = k_lvl && !k_old;
            kfall = !k_lvl && k_old;
            if (cfall) begin
                m_sr.delete();
                for (int c = 0; c < NCH; c++) begin
                    m_sr.push_back(m_code[c][1]);
                    m_sr.push_back(m_code[c][0]);
                end
            end else if (sel && kfall) begin
                void'(m_sr.pop_front());
                m_sr.push_back(m_din);
            end
            if (sel && krise) m_din = sdi;
            for (int c = 0; c < NCH; c++) begin
                if (crise) begin
                    m_code[c] = m_pv[c] ? m_pend[c] : 3;
                    m_pv[c] = 0;
                end
                if (we[c]) begin
                    if (sel) begin m_pv[c] = 1; m_pend[c] = int'(wcode[c*2 +: 2]); end
                    else m_code[c] = int'(wcode[c*2 +: 2]);
                end
            end
            c_old = c_lvl; c_lvl = c_in; c_in = csn;
            k_old = k_lvl; k_lvl = k_in; k_in = sclk;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (sdo !== model_sdo()) begin
                errors++;
                $display("FAIL R4 per-cycle model: act %b exp %b at %0t", sdo, model_sdo(), $time);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: act %h exp %h", req, act, exp);
        end
    endtask

    task automatic strobe(input int ch, input logic [1:0] c);
        @(negedge clk);
        we[ch] = 1'b1;
        wcode[ch*2 +: 2] = c;
        @(negedge clk);
        we = '0;
    endtask

    // reads nbits, left-aligned in got; up is sent msb first; strobes sch at bit 3 if sch >= 0
    task automatic read_frame(input int nbits, input logic [15:0] up,
                              input int sch, input logic [1:0] scode,
                              output logic [15:0] got);
        got = '0;
        @(negedge clk);
        csn = 1'b0;
        tick(8);
        for (int k = 0; k < nbits; k++) begin
            sdi = up[15-k];
            tick(6);
            got[15-k] = sdo;
            sclk = 1'b1;
            tick(6);
            chk("R4 hold across rising edge", {15'd0, sdo}, {15'd0, got[15-k]});
            sclk = 1'b0;
            if (k == 3 && sch >= 0) begin
                we[sch] = 1'b1;
                wcode[sch*2 +: 2] = scode;
                tick(1);
                we = '0;
            end
        end
        tick(6);
        csn = 1'b1;
        tick(8);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: act timeout exp completion");
        finish_run();
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [15:0] got;
        tick(5);
        rst = 1'b0;
        tick(3);
        chk("R8 reset state sdo", {15'd0, sdo}, 16'd1);

        // R1 / R2: single overload on channel 1
        strobe(1, 2'b10);
        tick(2);
        chk("R2 flag low on fault", {15'd0, sdo}, 16'd0);
        read_frame(8, 16'h0000, -1, 2'b11, got);
        chk("R3 R1 frame order", got, {8'b11_10_11_11, 8'h00});
        chk("R6 cleared on release", {15'd0, sdo}, 16'd1);

        // R1 overwrite, R5 cascade
        strobe(0, 2'b00);
        strobe(1, 2'b01);
        strobe(2, 2'b10);
        strobe(0, 2'b10);
        tick(2);
        chk("R2 flag low several faults", {15'd0, sdo}, 16'd0);
        read_frame(16, {8'b0110_1001, 8'h00}, -1, 2'b11, got);
        chk("R1 latest write wins", {8'd0, got[15:8]}, {8'd0, 8'b10_01_10_11});
        chk("R5 upstream bits follow", {8'd0, got[7:0]}, {8'd0, 8'b0110_1001});
        chk("R6 cleared after cascade read", {15'd0, sdo}, 16'd1);

        // R7 strobe during read is deferred
        read_frame(8, 16'hFFFF, 2, 2'b01, got);
        chk("R7 frame unaffected by strobe", got, {8'hFF, 8'h00});
        chk("R7 pending applied after release", {15'd0, sdo}, 16'd0);
        read_frame(8, 16'h0000, -1, 2'b11, got);
        chk("R7 pending code in next frame", got, {8'b11_11_01_11, 8'h00});
        chk("R2 flag high when all normal", {15'd0, sdo}, 16'd1);

        // R9 clock activity while deselected
        strobe(3, 2'b00);
        tick(2);
        for (int t = 0; t < 5; t++) begin
            sclk = 1'b1; sdi = t[0];
            tick(6);
            sclk = 1'b0;
            tick(6);
            chk("R9 sdo steady while deselected", {15'd0, sdo}, 16'd0);
        end
        read_frame(8, 16'h0000, -1, 2'b11, got);
        chk("R9 codes untouched by idle clocks", got, {8'b11_11_11_00, 8'h00});

        // R8 reset during a read with a pending code
        strobe(0, 2'b01);
        @(negedge clk);
        csn = 1'b0;
        tick(8);
        strobe(1, 2'b10);
        rst = 1'b1;
        tick(3);
        rst = 1'b0;
        tick(6);
        csn = 1'b1;
        tick(8);
        chk("R8 reset discards codes and pending", {15'd0, sdo}, 16'd1);

        finish_run();
    end

endmodule